// File: doc/BRIEF.md
# Waveform Buffer Read-Pointer Controller

This block is the digital control core of a buffered 12-bit digital-to-analog converter. It holds a table of sample words and a byte-wide register interface. A read pointer walks through the table on a hardware or software trigger. The word under the pointer is presented as the converter input code. The analog converter itself is not part of this block.

Software programs an upper limit for the pointer and picks one of three traversal patterns:

- **Wrap:** restart at word 0 after the limit.
- **Swing:** bounce between 0 and the limit.
- **Single pass:** stop at the limit.

Three sticky status flags mark the pointer reaching the limit, reaching zero, or reaching a watermark a chosen distance below the limit. Each flag can raise an interrupt. When DMA is selected, the flags raise a DMA request instead, and the DMA-done acknowledge clears them.

Register byte map: table word n low byte at 2n, table word n upper bits at 2n+1, status at 0x20, control A at 0x21, control B at 0x22, pointer register at 0x23. Reads are combinational. Addresses above 0x23 read 0, and writes to them are dropped.

Top module: `wbuf_ctrl`

## Requirements
- R1: Table word n is written and read as a low byte at offset 2n and bits [11:8] at offset 2n+1, whose upper nibble reads 0. After reset, all words are 0 and status reads 0x02. Control A and control B read 0x00, and the pointer register reads 0x0F (limit 15, pointer 0).
- R2: While the buffer enable (control B bit 0) is 0, `code_o` is word 0. While it is 1, `code_o` is the word at the pointer.
- R3: Mode field (control B bits [2:1]): 00 is wrap. An advance from a pointer at or above the limit goes to 0, otherwise the pointer increments. Code 11 behaves as 00. An advance from a pointer at or below the limit never leaves it above the limit.
- R4: Mode 01 is swing. The pointer counts up to the limit, then down to 0, then up again, turning around at each end.
- R5: Mode 10 is single pass. The pointer increments until it equals the limit and then holds, ignoring triggers until the pointer register is rewritten.
- R6: Writing control A with bit 4 set issues one software advance. It does so only if the same written byte has bit 7 (block enable) and bit 5 (software trigger select) set and the buffer is enabled. Bit 4 always reads 0.
- R7: With bit 5 of control A at 0, each rising edge of `hw_trig_i` yields exactly one advance, visible two clock edges after the input rises. With bit 5 at 1, `hw_trig_i` is ignored.
- R8: While the block enable (control A bit 7) is 0, no trigger moves the pointer.
- R9: Status bits 0, 1 and 2 are set one cycle after their condition becomes true, and only when it becomes true:
  - bit 0 (bottom): pointer equals limit;
  - bit 1 (top): pointer is 0;
  - bit 2 (watermark): pointer equals limit minus (watermark field + 1), where the watermark field is control B bits [4:3].
- R10: Writing status clears each flag whose written bit is 0 and keeps each flag whose bit is 1. A flag being set in the same cycle wins over the clear.
- R11: Control A bits [2:0] enable bottom, top and watermark flags onto a request. With DMA select (control B bit 7) at 0, the request drives `irq_o`; at 1, it drives `dma_req_o` and `irq_o` stays low. A `dma_done_i` pulse with DMA selected clears all flags.
- R12: Writing the pointer register loads the limit from bits [3:0] and the pointer from bits [7:4]. It overrides a same-cycle advance and restarts the swing direction upward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register byte write strobe |
| reg_addr_i | input | 6 | Register byte address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| hw_trig_i | input | 1 | Hardware advance trigger, rising-edge sensitive |
| dma_done_i | input | 1 | DMA transfer done, clears flags in DMA mode |
| code_o | output | 12 | Converter input code |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA request |

## Verification
The directed tests drive each mode across its turning points:
- **Wrap** at the limit. A design that compared with the wrong bound would show word limit+1 or skip the limit word.
- **Swing** at both ends. An off-by-one reversal would repeat the end word or jump past it.
- **Single pass** holding at the limit, then restarting on a rewrite of the pointer register. A design that kept counting or never rearmed would be caught.

On the flag side, the tests cover:
- the watermark position for a non-zero distance, where an off-by-one lands one word early or late;
- flags staying clear while a condition merely persists, where a level-sensitive design would re-set them at once;
- a partial write-zero clear;
- routing moving between `irq_o` and `dma_req_o`, and DMA-done clearing the flags.

Trigger qualification is also probed:
- a software trigger with hardware select;
- a long hardware pulse, which must count once;
- triggers while disabled.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  typedef enum logic [1:0] {
    MODE_WRAP  = 2'b00,
    MODE_SWING = 2'b01,
    MODE_ONCE  = 2'b10,
    MODE_RSVD  = 2'b11
  } seq_mode_e;

  // control A layout: {en, ref_sel, trig_sw, strobe(read 0), low_pwr, ien[2:0]}
  typedef struct packed {
    logic       en;
    logic       ref_sel;
    logic       trig_sw;
    logic       low_pwr;
    logic [2:0] ien;
  } ctl_a_t;

  // control B layout: {dma_en, 2'b0, wm[1:0], mode[1:0], buf_en}
  typedef struct packed {
    logic       dma_en;
    logic [1:0] wm;
    seq_mode_e  mode;
    logic       buf_en;
  } ctl_b_t;

  localparam int FLAG_BOT = 0;
  localparam int FLAG_TOP = 1;
  localparam int FLAG_WM  = 2;
  localparam int NFLAGS   = 3;

endpackage

// File: rtl/wbuf_table.sv
module wbuf_table #(
  parameter int WORDS    = 16,
  parameter int SAMPLE_W = 12,
  localparam int PTR_W   = $clog2(WORDS),
  localparam int HI_W    = SAMPLE_W - 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [PTR_W-1:0]    idx_i,
  input  logic                hi_sel_i,
  input  logic [7:0]          wdata_i,
  input  logic [PTR_W-1:0]    ptr_i,
  input  logic                buf_en_i,
  output logic [7:0]          rbyte_o,
  output logic [SAMPLE_W-1:0] code_o
);

  logic [SAMPLE_W-1:0] mem_q [WORDS];
  logic [SAMPLE_W-1:0] rd_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      if (hi_sel_i) mem_q[idx_i][SAMPLE_W-1:8] <= wdata_i[HI_W-1:0];
      else          mem_q[idx_i][7:0]          <= wdata_i;
    end
  end

  always_comb begin
    rd_word = mem_q[idx_i];
    rbyte_o = hi_sel_i ? {{(8-HI_W){1'b0}}, rd_word[SAMPLE_W-1:8]} : rd_word[7:0];
  end

  assign code_o = buf_en_i ? mem_q[ptr_i] : mem_q[0];

endmodule

// File: rtl/wbuf_seq.sv
module wbuf_seq
  import wbuf_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hw_trig_i,
  input  logic             hw_ok_i,
  input  logic             sw_fire_i,
  input  seq_mode_e        mode_i,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_ptr_i,
  input  logic [PTR_W-1:0] load_lim_i,
  output logic             step_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic [PTR_W-1:0] lim_o
);

  logic             hw_q, hw_qq;
  logic             down_q, down_d;
  logic [PTR_W-1:0] ptr_q, ptr_d, lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hw_q  <= 1'b0;
      hw_qq <= 1'b0;
    end else begin
      hw_q  <= hw_trig_i;
      hw_qq <= hw_q;
    end
  end

  assign step_o = (hw_q & ~hw_qq & hw_ok_i) | sw_fire_i;

  always_comb begin
    ptr_d  = ptr_q;
    down_d = down_q;
    unique case (mode_i)
      MODE_SWING: begin
        if (!down_q) begin
          if (ptr_q >= lim_q) begin
            down_d = 1'b1;
            ptr_d  = (lim_q == '0) ? '0 : lim_q - 1'b1;
          end else begin
            ptr_d = ptr_q + 1'b1;
          end
        end else if (ptr_q == '0) begin
          down_d = 1'b0;
          ptr_d  = (lim_q == '0) ? '0 : PTR_W'(1);
        end else begin
          ptr_d = ptr_q - 1'b1;
        end
      end
      MODE_ONCE: if (ptr_q < lim_q) ptr_d = ptr_q + 1'b1;
      default:   ptr_d = (ptr_q >= lim_q) ? '0 : ptr_q + 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      lim_q  <= '1;
      down_q <= 1'b0;
    end else if (load_i) begin
      ptr_q  <= load_ptr_i;
      lim_q  <= load_lim_i;
      down_q <= 1'b0;
    end else if (step_o) begin
      ptr_q  <= ptr_d;
      down_q <= down_d;
    end
  end

  assign ptr_o = ptr_q;
  assign lim_o = lim_q;

endmodule

// File: rtl/wbuf_flags.sv
module wbuf_flags
  import wbuf_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [PTR_W-1:0]  lim_i,
  input  logic [1:0]        wm_i,
  input  logic              clr_wr_i,
  input  logic [NFLAGS-1:0] clr_keep_i,
  input  logic              dma_done_i,
  input  logic              dma_en_i,
  input  logic [NFLAGS-1:0] ien_i,
  output logic [NFLAGS-1:0] flags_o,
  output logic              irq_o,
  output logic              dma_req_o
);

  logic [NFLAGS-1:0] cond, cond_q, flags_q, keep;
  logic [PTR_W:0]    wm_pos;
  logic              pend;

  assign wm_pos = {1'b0, lim_i} - (PTR_W+1)'(wm_i) - 1'b1;

  always_comb begin
    cond           = '0;
    cond[FLAG_BOT] = (ptr_i == lim_i);
    cond[FLAG_TOP] = (ptr_i == '0);
    cond[FLAG_WM]  = !wm_pos[PTR_W] && (ptr_i == wm_pos[PTR_W-1:0]);
  end

  // reset state matches the conditions at reset: pointer 0, limit at maximum
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cond_q <= NFLAGS'(1) << FLAG_TOP;
    else         cond_q <= cond;
  end

  always_comb begin
    keep = flags_q;
    if (clr_wr_i)              keep = keep & clr_keep_i;
    if (dma_done_i && dma_en_i) keep = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= NFLAGS'(1) << FLAG_TOP;
    else         flags_q <= keep | (cond & ~cond_q);
  end

  assign pend      = |(flags_q & ien_i);
  assign irq_o     = pend & ~dma_en_i;
  assign dma_req_o = pend & dma_en_i;
  assign flags_o   = flags_q;

endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
  import wbuf_pkg::*;
#(
  parameter int WORDS    = 16,
  parameter int SAMPLE_W = 12,
  localparam int PTR_W   = $clog2(WORDS),
  localparam int ADDR_W  = $clog2(2*WORDS + 4)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [7:0]          reg_wdata_i,
  output logic [7:0]          reg_rdata_o,
  input  logic                hw_trig_i,
  input  logic                dma_done_i,
  output logic [SAMPLE_W-1:0] code_o,
  output logic                irq_o,
  output logic                dma_req_o
);

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2*WORDS);
  localparam logic [ADDR_W-1:0] A_CA   = ADDR_W'(2*WORDS + 1);
  localparam logic [ADDR_W-1:0] A_CB   = ADDR_W'(2*WORDS + 2);
  localparam logic [ADDR_W-1:0] A_PTR  = ADDR_W'(2*WORDS + 3);

  ctl_a_t            ca_q;
  ctl_b_t            cb_q;
  logic              tbl_hit, wr_stat, wr_ca, wr_cb, c2_load, sw_fire, step;
  logic [PTR_W-1:0]  ptr, lim;
  logic [NFLAGS-1:0] flags;
  logic [7:0]        tbl_byte, ptr_byte;

  assign tbl_hit = reg_addr_i < A_STAT;
  assign wr_stat = reg_we_i && reg_addr_i == A_STAT;
  assign wr_ca   = reg_we_i && reg_addr_i == A_CA;
  assign wr_cb   = reg_we_i && reg_addr_i == A_CB;
  assign c2_load = reg_we_i && reg_addr_i == A_PTR;

  // software advance qualified by the byte being written
  assign sw_fire = wr_ca && reg_wdata_i[7] && reg_wdata_i[5] && reg_wdata_i[4] && cb_q.buf_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ca_q <= '0;
      cb_q <= '{dma_en: 1'b0, wm: 2'b00, mode: MODE_WRAP, buf_en: 1'b0};
    end else begin
      if (wr_ca) ca_q <= '{en: reg_wdata_i[7], ref_sel: reg_wdata_i[6], trig_sw: reg_wdata_i[5],
                           low_pwr: reg_wdata_i[3], ien: reg_wdata_i[2:0]};
      if (wr_cb) cb_q <= '{dma_en: reg_wdata_i[7], wm: reg_wdata_i[4:3],
                           mode: seq_mode_e'(reg_wdata_i[2:1]), buf_en: reg_wdata_i[0]};
    end
  end

  wbuf_table #(.WORDS(WORDS), .SAMPLE_W(SAMPLE_W)) i_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (reg_we_i && tbl_hit),
    .idx_i    (reg_addr_i[PTR_W:1]),
    .hi_sel_i (reg_addr_i[0]),
    .wdata_i  (reg_wdata_i),
    .ptr_i    (ptr),
    .buf_en_i (cb_q.buf_en),
    .rbyte_o  (tbl_byte),
    .code_o   (code_o)
  );

  wbuf_seq #(.PTR_W(PTR_W)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hw_trig_i  (hw_trig_i),
    .hw_ok_i    (ca_q.en && !ca_q.trig_sw && cb_q.buf_en),
    .sw_fire_i  (sw_fire),
    .mode_i     (cb_q.mode),
    .load_i     (c2_load),
    .load_ptr_i (reg_wdata_i[4 +: PTR_W]),
    .load_lim_i (reg_wdata_i[0 +: PTR_W]),
    .step_o     (step),
    .ptr_o      (ptr),
    .lim_o      (lim)
  );

  wbuf_flags #(.PTR_W(PTR_W)) i_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ptr_i      (ptr),
    .lim_i      (lim),
    .wm_i       (cb_q.wm),
    .clr_wr_i   (wr_stat),
    .clr_keep_i (reg_wdata_i[NFLAGS-1:0]),
    .dma_done_i (dma_done_i),
    .dma_en_i   (cb_q.dma_en),
    .ien_i      (ca_q.ien),
    .flags_o    (flags),
    .irq_o      (irq_o),
    .dma_req_o  (dma_req_o)
  );

  always_comb begin
    ptr_byte              = '0;
    ptr_byte[4 +: PTR_W]  = ptr;
    ptr_byte[0 +: PTR_W]  = lim;
  end

  always_comb begin
    if (tbl_hit) reg_rdata_o = tbl_byte;
    else begin
      unique case (reg_addr_i)
        A_STAT:  reg_rdata_o = {{(8-NFLAGS){1'b0}}, flags};
        A_CA:    reg_rdata_o = {ca_q.en, ca_q.ref_sel, ca_q.trig_sw, 1'b0, ca_q.low_pwr, ca_q.ien};
        A_CB:    reg_rdata_o = {cb_q.dma_en, 2'b00, cb_q.wm, cb_q.mode, cb_q.buf_en};
        A_PTR:   reg_rdata_o = ptr_byte;
        default: reg_rdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/wbuf_ctrl_chk.sv
module wbuf_ctrl_chk
  import wbuf_pkg::*;
#(
  parameter int PTR_W  = 4,
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] A_CA = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [7:0]        reg_rdata_o,
  input logic              irq_o,
  input logic              dma_req_o,
  input logic              step,
  input logic              c2_load,
  input logic              sw_fire,
  input logic              blk_en,
  input seq_mode_e         mode,
  input logic [PTR_W-1:0]  ptr,
  input logic [PTR_W-1:0]  lim
);

  p_ptr_in_limit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !c2_load && ptr <= lim) |=> ptr <= lim);

  p_once_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_ONCE && ptr == lim && !c2_load) |=> $stable(ptr));

  p_strobe_reads0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_CA) |-> !reg_rdata_o[4]);

  p_disabled_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blk_en && !c2_load && !sw_fire) |=> $stable(ptr));

  p_route_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && dma_req_o));

endmodule

bind wbuf_ctrl wbuf_ctrl_chk #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .A_CA(A_CA)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .dma_req_o   (dma_req_o),
  .step        (step),
  .c2_load     (c2_load),
  .sw_fire     (sw_fire),
  .blk_en      (ca_q.en),
  .mode        (cb_q.mode),
  .ptr         (ptr),
  .lim         (lim)
);

// File: tb/test_wbuf_ctrl.sv
`timescale 1ns/1ps
module test_wbuf_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        hw = 1'b0;
  logic        dma_done = 1'b0;
  logic [11:0] code;
  logic        irq, dreq;

  int checks = 0;
  int fails  = 0;
  logic [7:0] c0_base = 8'hA0;

  localparam logic [5:0] A_STAT = 6'h20, A_CA = 6'h21, A_CB = 6'h22, A_PTR = 6'h23;

  always #2 clk = ~clk;

  wbuf_ctrl i_wbuf_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .hw_trig_i(hw), .dma_done_i(dma_done), .code_o(code),
    .irq_o(irq), .dma_req_o(dreq)
  );

  function automatic logic [11:0] wv(int n);
    return 12'((n * 12'h111 + 12'h05A) & 12'hFFF);
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [7:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ptr_is(string tag, int exp);
    logic [7:0] d;
    rd(A_PTR, d);
    chk(tag, int'(d[7:4]), exp);
  endtask

  task automatic trig();
    wr(A_CA, c0_base | 8'h10);
  endtask

  task automatic hw_pulse();
    @(negedge clk); hw = 1'b1;
    idle(4);
    hw = 1'b0;
    idle(3);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(A_STAT, d); chk("R1 status reset", d, 8'h02);
    rd(A_CA, d);   chk("R1 ctlA reset", d, 8'h00);
    rd(A_CB, d);   chk("R1 ctlB reset", d, 8'h00);
    rd(A_PTR, d);  chk("R1 ptr reg reset", d, 8'h0F);
    rd(6'h07, d);  chk("R1 word reset", d, 8'h00);
    chk("R1 code reset", code, 0);
    chk("R11 irq reset", irq, 0);
    chk("R11 dma reset", dreq, 0);
  endtask

  task automatic t_table();
    logic [7:0] d;
    for (int n = 0; n < 16; n++) begin
      wr(6'(2*n), wv(n)[7:0]);
      wr(6'(2*n+1), {4'hF, wv(n)[11:8]});
    end
    rd(6'h06, d); chk("R1 low byte w3", d, wv(3)[7:0]);
    rd(6'h07, d); chk("R1 high nibble w3", d, {4'h0, wv(3)[11:8]});
    rd(6'h3F, d); chk("R1 unmapped reads 0", d, 0);
  endtask

  task automatic t_wrap();
    int exp[5] = '{1, 2, 3, 0, 1};
    int exr[3] = '{1, 2, 0};
    c0_base = 8'hA0;
    wr(A_CA, c0_base);
    wr(A_CB, 8'h01);
    wr(A_PTR, 8'h03);
    chk("R2 code at ptr0", code, wv(0));
    for (int i = 0; i < 5; i++) begin
      trig();
      ptr_is("R3 wrap ptr", exp[i]);
      chk("R2 code follows ptr", code, wv(exp[i]));
    end
    wr(A_CB, 8'h07);
    wr(A_PTR, 8'h02);
    for (int i = 0; i < 3; i++) begin
      trig();
      ptr_is("R3 reserved as wrap", exr[i]);
    end
  endtask

  task automatic t_swing();
    int exp[7] = '{1, 2, 3, 2, 1, 0, 1};
    wr(A_CB, 8'h03);
    wr(A_PTR, 8'h03);
    for (int i = 0; i < 7; i++) begin
      trig();
      ptr_is("R4 swing ptr", exp[i]);
    end
    trig();
    trig();
    ptr_is("R4 swing before reload", 3);
    trig();
    ptr_is("R4 swing descending", 2);
    wr(A_PTR, 8'h23);
    trig();
    ptr_is("R12 reload restarts upward", 3);
  endtask

  task automatic t_once();
    int exp[4] = '{1, 2, 2, 2};
    wr(A_CB, 8'h05);
    wr(A_PTR, 8'h02);
    for (int i = 0; i < 4; i++) begin
      trig();
      ptr_is("R5 single pass ptr", exp[i]);
    end
    wr(A_PTR, 8'h02);
    trig();
    ptr_is("R5 rearm after rewrite", 1);
  endtask

  task automatic t_bufoff();
    logic [7:0] d;
    wr(A_CB, 8'h00);
    wr(A_PTR, 8'h35);
    chk("R2 buffer off gives word0", code, wv(0));
    trig();
    rd(A_PTR, d);
    chk("R6 no advance with buffer off", d, 8'h35);
  endtask

  task automatic t_hw();
    logic [7:0] d;
    c0_base = 8'h80;
    wr(A_CB, 8'h01);
    wr(A_PTR, 8'h05);
    wr(A_CA, 8'h90);
    ptr_is("R6 sw strobe ignored with hw select", 0);
    rd(A_CA, d);
    chk("R6 strobe bit reads 0", d, 8'h80);
    @(negedge clk); hw = 1'b1;
    @(negedge clk);
    ptr_is("R7 no advance after one edge", 0);
    @(negedge clk);
    ptr_is("R7 advance after two edges", 1);
    idle(4); hw = 1'b0; idle(3);
    ptr_is("R7 long pulse counts once", 1);
    hw_pulse();
    ptr_is("R7 second pulse", 2);
    wr(A_CA, 8'hA0);
    hw_pulse();
    ptr_is("R7 hw ignored with sw select", 2);
    wr(A_CA, 8'h00);
    hw_pulse();
    ptr_is("R8 hw ignored while disabled", 2);
    wr(A_CA, 8'h30);
    ptr_is("R8 sw ignored while disabled", 2);
  endtask

  task automatic t_flags();
    logic [7:0] d;
    int exp[4] = '{8'h04, 8'h04, 8'h05, 8'h07};
    c0_base = 8'hA0;
    wr(A_CA, c0_base);
    wr(A_CB, 8'h09);
    wr(A_PTR, 8'h15);
    idle(1);
    wr(A_STAT, 8'h00);
    rd(A_STAT, d); chk("R10 clear all", d, 0);
    trig(); idle(1);
    rd(A_STAT, d); chk("R9 no flag at ptr2", d, 0);
    for (int i = 0; i < 4; i++) begin
      trig(); idle(1);
      rd(A_STAT, d); chk("R9 flags after step", d, exp[i]);
    end
    wr(A_STAT, 8'h06);
    rd(A_STAT, d); chk("R10 partial clear", d, 8'h06);
    wr(A_STAT, 8'h00);
    idle(3);
    rd(A_STAT, d); chk("R9 no re-set while held", d, 0);
  endtask

  task automatic t_route();
    logic [7:0] d;
    c0_base = 8'hA2;
    wr(A_CA, c0_base);
    wr(A_CB, 8'h01);
    wr(A_PTR, 8'h11);
    idle(1);
    wr(A_STAT, 8'h00);
    trig(); idle(1);
    chk("R11 irq on top flag", irq, 1);
    chk("R11 no dma when irq mode", dreq, 0);
    wr(A_STAT, 8'h00);
    chk("R11 irq drops on clear", irq, 0);
    wr(A_CB, 8'h81);
    trig(); idle(1);
    chk("R11 bottom not enabled", irq | dreq, 0);
    trig(); idle(1);
    chk("R11 dma request", dreq, 1);
    chk("R11 irq masked in dma mode", irq, 0);
    @(negedge clk); dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
    chk("R11 dma done drops request", dreq, 0);
    rd(A_STAT, d); chk("R11 dma done clears flags", d, 0);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_table();
    t_wrap();
    t_swing();
    t_once();
    t_bufoff();
    t_hw();
    t_flags();
    t_route();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule